// File: doc/BRIEF.md
# Cache Line Maintenance Controller

This block carries out one maintenance command at a time on the state of a single cache line. The line's state is its valid, dirty and lock bits, which the surrounding cache presents on the inputs together with the result of the tag compare. The block returns the new state as a one-cycle write strobe with three state bits. When a command needs memory traffic, it raises a writeback or refill request and waits for the matching acknowledge. The tag array, the data array and memory lie outside the block and are reached only through these signals.

Six commands are supported: invalidate, writeback, writeback-and-invalidate, prefetch-and-lock, unlock and line reset. The lock bit rules every command. A locked line survives any invalidation, unlock changes only locked lines, and a block built as an instruction cache never writes back. An index flag applies a command to the line at the presented index whatever its tag is, which is how software sweeps the whole cache. A sync output is high only when no earlier command has work left, whether a state write or a memory handshake.

Top module: `cline_maint`

## Requirements
- R1: Invalidate (op 0) on a targeted valid line that is not locked writes valid=0, dirty=0, lock=0 in the cycle after acceptance. On a locked line it writes nothing.
- R2: Writeback (op 1) on a targeted valid dirty line of a data cache raises wb_req in the cycle after acceptance and holds it until wb_ack is sampled high. In the next cycle it writes valid=1, dirty=0 with the lock bit unchanged. A clean line causes no write and no request.
- R3: Writeback-and-invalidate (op 2) on a dirty targeted line of a data cache first writes back, as in R2. It then writes valid=0 if the line is unlocked, or valid=1, dirty=0, lock=1 if it is locked. A clean unlocked line is invalidated at once with no request. A clean locked line is left untouched.
- R4: Prefetch-and-lock (op 3) on a line that is present (line_hit and line_valid) and unlocked writes lock=1 and keeps the other bits. On an absent line with a free way, it raises fill_req until fill_ack and then writes valid=1, dirty=0, lock=1.
- R5: Prefetch-and-lock on an absent line while set_full is high pulses lock_err for exactly one cycle. It writes nothing and raises no fill request.
- R6: Unlock (op 4) on a targeted valid locked line writes lock=0 and keeps valid and dirty. On an unlocked line it writes nothing. Op codes 6 and 7 write nothing and raise no request.
- R7: With IS_ICACHE=1, wb_req never rises. Writeback writes nothing. Writeback-and-invalidate acts like invalidate, so a dirty unlocked line becomes valid=0, dirty=0.
- R8: Line reset (op 5) writes valid=0, dirty=0, lock=0 whatever the tag match, lock and dirty bits are, and raises no request.
- R9: A line is targeted when it is valid and either line_hit or cmd_idx is high. With both low, ops 0, 1, 2 and 4 write nothing.
- R10: cmd_ready is low from the cycle after a writeback or refill starts until its acknowledge has been sampled. Commands presented in that window are not accepted.
- R11: sync is high exactly when no handshake is outstanding and no state write is being presented. It is low in the cycle that carries the write of an accepted command.
- R12: After reset, cmd_ready and sync are high, and upd_we, wb_req, fill_req and lock_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Operation code (0 inv, 1 wb, 2 wb+inv, 3 lock, 4 unlock, 5 reset) |
| cmd_idx | input | 1 | Apply to the indexed line regardless of the tag |
| line_hit | input | 1 | Tag compare matched |
| line_valid | input | 1 | Current valid bit |
| line_dirty | input | 1 | Current dirty bit |
| line_lock | input | 1 | Current lock bit |
| set_full | input | 1 | Every way of the set is locked |
| upd_we | output | 1 | State write strobe |
| upd_valid | output | 1 | New valid bit |
| upd_dirty | output | 1 | New dirty bit |
| upd_lock | output | 1 | New lock bit |
| wb_req | output | 1 | Writeback to memory requested |
| wb_ack | input | 1 | Writeback reached memory |
| fill_req | output | 1 | Refill from memory requested |
| fill_ack | input | 1 | Refill completed |
| lock_err | output | 1 | Lock could not be honoured (one cycle) |
| sync | output | 1 | All earlier commands complete |

## Verification
The hardest situation to reach is a new command pushing at the block while a writeback is still outstanding. To reach it, the stimulus starts a writeback, keeps cmd_valid high with a different command for several cycles while wb_ack is withheld, and then drops it before the acknowledge. The check is that nothing is accepted and sync stays low throughout. A second copy built as an instruction cache receives dirty lines under writeback commands to show that no request ever appears.

// File: rtl/cline_maint.sv
module cline_maint #(
  parameter bit IS_ICACHE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic       cmd_idx,
  input  logic       line_hit,
  input  logic       line_valid,
  input  logic       line_dirty,
  input  logic       line_lock,
  input  logic       set_full,
  output logic       upd_we,
  output logic       upd_valid,
  output logic       upd_dirty,
  output logic       upd_lock,
  output logic       wb_req,
  input  logic       wb_ack,
  output logic       fill_req,
  input  logic       fill_ack,
  output logic       lock_err,
  output logic       sync
);
  localparam logic [2:0] OP_INV = 3'd0, OP_WB = 3'd1, OP_WBI = 3'd2,
                         OP_LOCK = 3'd3, OP_UNLK = 3'd4, OP_RST = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL} st_t;
  st_t st;
  logic pv, pd, pl;

  logic accept, target, present, dirty_wb;
  logic go_we, go_wb, go_fill, go_err, nv, nd, nl;

  assign cmd_ready = (st == ST_IDLE);
  assign sync      = (st == ST_IDLE) && !upd_we;
  assign accept    = cmd_valid && cmd_ready;
  assign target    = (line_hit || cmd_idx) && line_valid;
  assign present   = line_hit && line_valid;
  assign dirty_wb  = !IS_ICACHE && target && line_dirty;

  always_comb begin
    go_we = 1'b0; go_wb = 1'b0; go_fill = 1'b0; go_err = 1'b0;
    nv = line_valid; nd = line_dirty; nl = line_lock;
    case (cmd_op)
      OP_INV: if (target && !line_lock) begin
        go_we = 1'b1; nv = 1'b0; nd = 1'b0;
      end
      OP_WB: if (dirty_wb) begin
        go_wb = 1'b1; nd = 1'b0;
      end
      OP_WBI: begin
        if (dirty_wb) begin
          go_wb = 1'b1; nd = 1'b0; nv = line_lock;
        end else if (target && !line_lock) begin
          go_we = 1'b1; nv = 1'b0; nd = 1'b0;
        end
      end
      OP_LOCK: begin
        if (present) begin
          go_we = !line_lock; nl = 1'b1;
        end else if (set_full) begin
          go_err = 1'b1;
        end else begin
          go_fill = 1'b1; nv = 1'b1; nd = 1'b0; nl = 1'b1;
        end
      end
      OP_UNLK: if (target && line_lock) begin
        go_we = 1'b1; nl = 1'b0;
      end
      OP_RST: begin
        go_we = 1'b1; nv = 1'b0; nd = 1'b0; nl = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      {pv, pd, pl} <= '0;
      {upd_we, upd_valid, upd_dirty, upd_lock} <= '0;
      wb_req <= 1'b0; fill_req <= 1'b0; lock_err <= 1'b0;
    end else begin
      upd_we   <= 1'b0;
      lock_err <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          lock_err <= go_err;
          if (go_wb || go_fill) begin
            {pv, pd, pl} <= {nv, nd, nl};
            wb_req   <= go_wb;
            fill_req <= go_fill;
            st       <= go_wb ? ST_WB : ST_FILL;
          end else if (go_we) begin
            upd_we <= 1'b1;
            {upd_valid, upd_dirty, upd_lock} <= {nv, nd, nl};
          end
        end
        ST_WB: if (wb_ack) begin
          wb_req <= 1'b0; upd_we <= 1'b1;
          {upd_valid, upd_dirty, upd_lock} <= {pv, pd, pl};
          st <= ST_IDLE;
        end
        ST_FILL: if (fill_ack) begin
          fill_req <= 1'b0; upd_we <= 1'b1;
          {upd_valid, upd_dirty, upd_lock} <= {pv, pd, pl};
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

module cline_maint_chk #(
  parameter bit IS_ICACHE = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic       cmd_idx,
  input logic       line_hit,
  input logic       line_valid,
  input logic       line_dirty,
  input logic       line_lock,
  input logic       set_full,
  input logic       upd_we,
  input logic       upd_valid,
  input logic       upd_dirty,
  input logic       upd_lock,
  input logic       wb_req,
  input logic       wb_ack,
  input logic       fill_req,
  input logic       fill_ack,
  input logic       lock_err,
  input logic       sync
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  a_r1_locked_survives: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd0 && line_lock |=> !upd_we);
  a_r2_wb_held: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req);
  a_r2_wb_clears_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && wb_ack |=> upd_we && !upd_dirty && !wb_req);
  a_r4_fill_locks: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && fill_ack |=> upd_we && upd_valid && upd_lock && !upd_dirty);
  a_r5_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |=> !lock_err);
  a_r5_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |-> !upd_we && !fill_req);
  a_r7_icache_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    IS_ICACHE |-> !wb_req);
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd5 |=> upd_we && !upd_valid && !upd_dirty && !upd_lock);
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req || fill_req) |-> !cmd_ready);
  a_r11_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> !upd_we && !wb_req && !fill_req);
endmodule

bind cline_maint cline_maint_chk #(.IS_ICACHE(IS_ICACHE)) u_chk (.*);

// File: tb/test_cline_maint.sv
module test_cline_maint;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_idx = 0, line_hit = 0, line_valid = 0, line_dirty = 0;
  logic line_lock = 0, set_full = 0, wb_ack = 0, fill_ack = 0, ic_valid = 0;
  logic [2:0] cmd_op = 3'd7;
  logic cmd_ready, upd_we, upd_valid, upd_dirty, upd_lock, wb_req, fill_req, lock_err, sync;
  logic ic_ready, ic_we, ic_v, ic_d, ic_l, ic_wb, ic_fill, ic_err, ic_sync;

  int n_tot = 0, n_bad = 0;
  bit ic_wb_seen = 0;
  string tag = "R12";

  always #(CLK_NS/2) clk = ~clk;

  cline_maint #(.IS_ICACHE(1'b0)) i_cline_maint (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_idx, .line_hit, .line_valid,
    .line_dirty, .line_lock, .set_full, .upd_we, .upd_valid, .upd_dirty, .upd_lock,
    .wb_req, .wb_ack, .fill_req, .fill_ack, .lock_err, .sync);

  cline_maint #(.IS_ICACHE(1'b1)) i_cline_maint_ic (
    .clk, .rst_n, .cmd_valid(ic_valid), .cmd_ready(ic_ready), .cmd_op, .cmd_idx,
    .line_hit, .line_valid, .line_dirty, .line_lock, .set_full, .upd_we(ic_we),
    .upd_valid(ic_v), .upd_dirty(ic_d), .upd_lock(ic_l), .wb_req(ic_wb), .wb_ack(1'b0),
    .fill_req(ic_fill), .fill_ack, .lock_err(ic_err), .sync(ic_sync));

  task automatic chk(string t, string what, logic [7:0] act, logic [7:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  // behavioural reference model (data cache)
  int m_st = 0;
  bit e_we = 0, e_v = 0, e_d = 0, e_l = 0, e_wb = 0, e_fill = 0, e_err = 0;
  bit p_v, p_d, p_l;
  always @(posedge clk) begin
    bit tg, pr;
    if (!rst_n) begin
      m_st = 0; e_we = 0; e_wb = 0; e_fill = 0; e_err = 0; e_v = 0; e_d = 0; e_l = 0;
    end else begin
      e_we = 0; e_err = 0;
      tg = (line_hit || cmd_idx) && line_valid;
      pr = line_hit && line_valid;
      if (m_st == 1 && wb_ack) begin
        e_wb = 0; e_we = 1; {e_v, e_d, e_l} = {p_v, p_d, p_l}; m_st = 0;
      end else if (m_st == 2 && fill_ack) begin
        e_fill = 0; e_we = 1; {e_v, e_d, e_l} = {p_v, p_d, p_l}; m_st = 0;
      end else if (m_st == 0 && cmd_valid) begin
        case (cmd_op)
          3'd0: if (tg && !line_lock) begin e_we = 1; {e_v, e_d, e_l} = 3'b000; end
          3'd1: if (tg && line_dirty) begin
                  e_wb = 1; m_st = 1; {p_v, p_d, p_l} = {1'b1, 1'b0, line_lock};
                end
          3'd2: if (tg && line_dirty) begin
                  e_wb = 1; m_st = 1; {p_v, p_d, p_l} = {line_lock, 1'b0, line_lock};
                end else if (tg && !line_lock) begin
                  e_we = 1; {e_v, e_d, e_l} = 3'b000;
                end
          3'd3: if (pr) begin
                  if (!line_lock) begin e_we = 1; {e_v, e_d, e_l} = {1'b1, line_dirty, 1'b1}; end
                end else if (set_full) e_err = 1;
                else begin e_fill = 1; m_st = 2; {p_v, p_d, p_l} = 3'b101; end
          3'd4: if (tg && line_lock) begin
                  e_we = 1; {e_v, e_d, e_l} = {1'b1, line_dirty, 1'b0};
                end
          3'd5: begin e_we = 1; {e_v, e_d, e_l} = 3'b000; end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (ic_wb) ic_wb_seen = 1;
    if (rst_n) begin
      chk("R10", "cmd_ready", cmd_ready, 8'(m_st == 0));
      chk("R11", "sync", sync, 8'(m_st == 0 && !e_we));
      chk(tag, "upd_we", upd_we, 8'(e_we));
      if (e_we) chk(tag, "upd_vdl", {upd_valid, upd_dirty, upd_lock}, {e_v, e_d, e_l});
      chk(tag, "wb_req", wb_req, 8'(e_wb));
      chk(tag, "fill_req", fill_req, 8'(e_fill));
      chk(tag, "lock_err", lock_err, 8'(e_err));
    end
  end

  task automatic setline(logic [2:0] op, bit idx, bit h, bit v, bit d, bit l, bit f);
    cmd_op = op; cmd_idx = idx; line_hit = h; line_valid = v;
    line_dirty = d; line_lock = l; set_full = f;
  endtask

  task automatic issue(string t, logic [2:0] op, bit idx, bit h, bit v, bit d, bit l, bit f);
    tag = t;
    setline(op, idx, h, v, d, l, f);
    cmd_valid = 1;
    forever begin
      @(negedge clk);
      if (cmd_ready) begin @(posedge clk); #1; break; end
    end
    cmd_valid = 0; cmd_op = 3'd7;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic ack_wb(int wait_cyc);
    repeat (wait_cyc) @(posedge clk);
    #1 wb_ack = 1;
    @(posedge clk); #1 wb_ack = 0;
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic ack_fill();
    #1 fill_ack = 1;
    @(posedge clk); #1 fill_ack = 0;
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic issue_ic(logic [2:0] op, bit d, bit l);
    setline(op, 1'b0, 1'b1, 1'b1, d, l, 1'b0);
    ic_valid = 1;
    @(posedge clk); #1 ic_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "ready", cmd_ready, 1); chk("R12", "sync", sync, 1);
    chk("R12", "outs", {upd_we, wb_req, fill_req, lock_err}, 0);
    rst_n = 1;
    @(posedge clk); #1;

    issue("R1", 3'd0, 0, 1, 1, 1, 0, 0);
    issue("R1", 3'd0, 0, 1, 1, 1, 1, 0);
    issue("R9", 3'd0, 0, 0, 1, 0, 0, 0);
    issue("R9", 3'd0, 1, 0, 1, 0, 0, 0);
    issue("R9", 3'd4, 0, 0, 1, 0, 1, 0);
    issue("R9", 3'd1, 0, 0, 1, 1, 0, 0);

    issue("R2", 3'd1, 0, 1, 1, 1, 0, 0);
    tag = "R10";
    setline(3'd0, 0, 1, 1, 0, 0, 0); cmd_valid = 1;
    repeat (4) @(posedge clk); #1 cmd_valid = 0;
    tag = "R2"; ack_wb(0);
    issue("R2", 3'd1, 0, 1, 1, 0, 0, 0);
    issue("R2", 3'd1, 1, 0, 1, 1, 1, 0); ack_wb(3);

    issue("R3", 3'd2, 0, 1, 1, 1, 0, 0); ack_wb(1);
    issue("R3", 3'd2, 0, 1, 1, 1, 1, 0); ack_wb(2);
    issue("R3", 3'd2, 0, 1, 1, 0, 0, 0);
    issue("R3", 3'd2, 0, 1, 1, 0, 1, 0);

    issue("R4", 3'd3, 0, 1, 1, 1, 0, 0);
    issue("R4", 3'd3, 0, 1, 1, 0, 1, 0);
    issue("R4", 3'd3, 0, 0, 0, 0, 0, 0); repeat (3) @(posedge clk); ack_fill();
    issue("R4", 3'd3, 1, 0, 1, 0, 0, 0); ack_fill();

    issue("R5", 3'd3, 0, 0, 0, 0, 0, 1);
    issue("R5", 3'd3, 0, 1, 0, 0, 0, 1);

    issue("R6", 3'd4, 0, 1, 1, 1, 1, 0);
    issue("R6", 3'd4, 0, 1, 1, 1, 0, 0);
    issue("R6", 3'd6, 1, 1, 1, 1, 1, 1);
    issue("R6", 3'd7, 1, 1, 1, 1, 1, 0);

    issue("R8", 3'd5, 0, 0, 1, 1, 1, 0);
    issue("R8", 3'd5, 0, 0, 0, 0, 0, 0);

    // back-to-back acceptance
    tag = "R11";
    setline(3'd0, 0, 1, 1, 0, 0, 0); cmd_valid = 1;
    @(posedge clk); #1 setline(3'd5, 0, 0, 0, 0, 0, 0);
    @(posedge clk); #1 cmd_valid = 0;
    repeat (3) @(posedge clk); #1;

    // instruction cache copy
    issue_ic(3'd1, 1, 0);
    @(negedge clk);
    chk("R7", "ic wb upd_we", ic_we, 0); chk("R7", "ic wb_req", ic_wb, 0);
    chk("R7", "ic ready", ic_ready, 1);
    #1 issue_ic(3'd2, 1, 0);
    @(negedge clk);
    chk("R7", "ic wbinv upd_we", ic_we, 1);
    chk("R7", "ic wbinv vdl", {ic_v, ic_d, ic_l}, 3'b000);
    chk("R7", "ic wbinv wb_req", ic_wb, 0);
    #1 issue_ic(3'd2, 1, 1);
    @(negedge clk);
    chk("R7", "ic wbinv locked upd_we", ic_we, 0);
    chk("R7", "ic sync", ic_sync, 1);
    repeat (2) @(negedge clk);
    chk("R7", "ic wb ever", ic_wb_seen, 0);

    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule